// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that completes one instruction on every clock edge. On each edge it fetches a word from its instruction store, decodes it, reads two operands from a 32-entry register file, runs the ALU, optionally reads or writes its data store, and commits the result and the next program counter. The subset covers register-to-register add, subtract, and, or and signed set-less-than, add-immediate, word load, word store and branch-on-equal.

Both stores are word arrays held inside the core. The instruction store is filled from the testbench before reset is released. The data store starts with undefined contents and is written only by store instructions. A debug port shows the current program counter and gives a combinational read of any register chosen by a select input. The program's effects are observed through this port.

Top module: `scalar_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0 and every register reads 0.
- R2: Every instruction that is not a taken branch advances the PC by exactly 4 on the next rising edge, so there is one instruction per clock.
- R3: An instruction with opcode 0x00 (bits 31:26) and funct (bits 5:0) 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs−rt, rs AND rt or rs OR rt to register rd (bits 15:11). Here rs is bits 25:21 and rt is bits 20:16.
- R4: Opcode 0x00 with funct 0x2A writes 1 to rd when rs is less than rt as signed two's-complement values, and writes 0 otherwise.
- R5: Opcode 0x08 writes rs plus the sign-extended bits 15:0 to register rt.
- R6: Opcode 0x2B stores register rt to the data word at address rs plus the sign-extended bits 15:0 and leaves every register unchanged.
- R7: Opcode 0x23 loads the data word at address rs plus the sign-extended bits 15:0 into register rt.
- R8: Opcode 0x04 sets the next PC to PC+4 plus the sign-extended bits 15:0 shifted left by two when rs equals rt, and to PC+4 when they differ.
- R9: Writes whose destination is register 0 are dropped, so register 0 always reads 0.
- R10: `dbg_pc` shows the current PC, and `dbg_reg_data` shows the register chosen by `dbg_reg_sel` in the same cycle.
- R11: Any other opcode, or opcode 0x00 with any other funct, changes no register and no data word and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_reg_sel | input | 5 | Register index for the debug read |
| dbg_pc | output | 32 | Current program counter |
| dbg_reg_data | output | 32 | Contents of the selected register |

## Verification
A wrong next-PC choice shows on `dbg_pc` one edge after the bad instruction, and every later PC is then shifted. A decode or ALU fault that corrupts a register stays hidden until that register is read through the debug port or feeds a branch compare. At that point the program path diverges and the PC trace shows it. A bad data-store write appears only after a later load copies the word into a register. The test program therefore loads back every stored word and finishes with a branch-to-self, so the final register contents expose any corrupted state.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_from_mem;
    logic    rf_we;
    logic    mem_we;
    logic    is_branch;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] alu_eval(input alu_op_e op, input logic [31:0] a,
                                           input logic [31:0] b);
    logic [31:0] r;
    unique case (op)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLT: r = {31'd0, ($signed(a) < $signed(b))};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] branch_target(input logic [31:0] seq_pc,
                                                input logic [31:0] imm_ext);
    return seq_pc + (imm_ext << 2);
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl.dst_is_rd   = 1'b0;
    ctrl.b_is_imm    = 1'b0;
    ctrl.wb_from_mem = 1'b0;
    ctrl.rf_we       = 1'b0;
    ctrl.mem_we      = 1'b0;
    ctrl.is_branch   = 1'b0;
    ctrl.alu_op      = ALU_ADD;
    case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.rf_we     = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.rf_we  = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.rf_we    = 1'b1;
      end
      OPC_LW: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.rf_we       = 1'b1;
      end
      OPC_SW: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e     op,
  input  logic [31:0] a,
  input  logic [31:0] b,
  output logic [31:0] y,
  output logic        is_zero
);
  assign y       = alu_eval(op, a, b);
  assign is_zero = (y == 32'd0);

  always_comb begin
    if (op == ALU_SLT) begin
      // R4
      slt_bool_chk: assert (y[31:1] == 31'd0);
    end
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(NREGS)-1:0] raddr_a,
  input  logic [$clog2(NREGS)-1:0] raddr_b,
  input  logic [$clog2(NREGS)-1:0] raddr_c,
  output logic [WIDTH-1:0]         rdata_a,
  output logic [WIDTH-1:0]         rdata_b,
  output logic [WIDTH-1:0]         rdata_c
);
  localparam int unsigned AW = $clog2(NREGS);

  logic [WIDTH-1:0] regs [NREGS];
  logic             wr_live;

  assign wr_live = we && (waddr != AW'(0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign rdata_c = regs[raddr_c];

  // R9
  r0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) regs[0] == '0);
endmodule

// File: rtl/scalar_core.sv
module scalar_core
  import sc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64,
  parameter int unsigned NREGS      = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  dbg_reg_sel,
  output logic [31:0] dbg_pc,
  output logic [31:0] dbg_reg_data
);
  localparam int unsigned IA_W = $clog2(IMEM_WORDS);
  localparam int unsigned DA_W = $clog2(DMEM_WORDS);
  localparam int unsigned RA_W = $clog2(NREGS);

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
  end

  logic [31:0] pc, seq_pc, next_pc, instr;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd;
  logic [15:0] imm16;
  logic [31:0] imm_ext;
  ctrl_t       ctrl;
  logic [31:0] rd_a, rd_b, alu_b, alu_y, mem_rdata, wb_data;
  logic [4:0]  wb_addr;
  logic        alu_zero, br_take;
  logic [DA_W-1:0] dmem_idx;

  // fetch and field split
  assign instr   = imem[pc[IA_W+1:2]];
  assign opcode  = instr[31:26];
  assign rs      = instr[25:21];
  assign rt      = instr[20:16];
  assign rd      = instr[15:11];
  assign funct   = instr[5:0];
  assign imm16   = instr[15:0];
  assign imm_ext = sext16(imm16);

  sc_decode u_decode (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  sc_regfile #(.NREGS(NREGS), .WIDTH(32)) u_regfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ctrl.rf_we),
    .waddr   (wb_addr[RA_W-1:0]),
    .wdata   (wb_data),
    .raddr_a (rs[RA_W-1:0]),
    .raddr_b (rt[RA_W-1:0]),
    .raddr_c (dbg_reg_sel[RA_W-1:0]),
    .rdata_a (rd_a),
    .rdata_b (rd_b),
    .rdata_c (dbg_reg_data)
  );

  assign alu_b = ctrl.b_is_imm ? imm_ext : rd_b;

  sc_alu u_alu (
    .op      (ctrl.alu_op),
    .a       (rd_a),
    .b       (alu_b),
    .y       (alu_y),
    .is_zero (alu_zero)
  );

  // data store: combinational read, write on the edge
  assign dmem_idx  = alu_y[DA_W+1:2];
  assign mem_rdata = dmem[dmem_idx];

  always_ff @(posedge clk) begin
    if (ctrl.mem_we) dmem[dmem_idx] <= rd_b;
  end

  assign wb_addr = ctrl.dst_is_rd ? rd : rt;
  assign wb_data = ctrl.wb_from_mem ? mem_rdata : alu_y;

  // next PC
  assign seq_pc  = pc + 32'd4;
  assign br_take = ctrl.is_branch && alu_zero;
  assign next_pc = br_take ? branch_target(seq_pc, imm_ext) : seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else        pc <= next_pc;
  end

  assign dbg_pc = pc;

  logic unused_bits;
  assign unused_bits = ^{pc[31:IA_W+2], pc[1:0], instr[10:6], alu_y[31:DA_W+2], alu_y[1:0]};

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_take |=> pc == $past(pc) + 32'd4);

  // R8
  br_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> pc == $past(seq_pc) + ($past(imm_ext) << 2));

  // R6
  st_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mem_we |-> !ctrl.rf_we);

  // R6
  st_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mem_we |=> dmem[$past(dmem_idx)] == $past(rd_b));
endmodule

// File: tb/scalar_core_bench.sv
module scalar_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_pc, dbg_reg_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  scalar_core u_scalar_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_reg_sel  (dbg_reg_sel),
    .dbg_pc       (dbg_pc),
    .dbg_reg_data (dbg_reg_data)
  );

  typedef struct {
    logic [31:0] pc;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [31:0] prog  [64];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_pc;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int s, input int t, input int d, input logic [5:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction

  // reference interpreter written from the requirements
  task automatic model_step(output string tag);
    logic [31:0] w, a, b, se, ea, nxt;
    logic [5:0]  op, fn;
    int          s, t, d;
    w   = prog[m_pc[7:2]];
    op  = w[31:26]; fn = w[5:0];
    s   = int'(w[25:21]); t = int'(w[20:16]); d = int'(w[15:11]);
    a   = m_reg[s]; b = m_reg[t];
    se  = {{16{w[15]}}, w[15:0]};
    ea  = a + se;
    nxt = m_pc + 32'd4;
    tag = "R2";
    if (op == 6'h00) begin
      if (fn == 6'h20 && d != 0) m_reg[d] = a + b;
      else if (fn == 6'h22 && d != 0) m_reg[d] = a - b;
      else if (fn == 6'h24 && d != 0) m_reg[d] = a & b;
      else if (fn == 6'h25 && d != 0) m_reg[d] = a | b;
      else if (fn == 6'h2A && d != 0) m_reg[d] = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    end else if (op == 6'h08) begin
      if (t != 0) m_reg[t] = ea;
    end else if (op == 6'h23) begin
      if (t != 0) m_reg[t] = m_mem[ea[7:2]];
    end else if (op == 6'h2B) begin
      m_mem[ea[7:2]] = b;
    end else if (op == 6'h04) begin
      tag = "R8";
      if (a == b) nxt = nxt + (se << 2);
    end
    m_pc = nxt;
  endtask

  task automatic drive_program(input int steps);
    string tg;
    for (int k = 0; k < steps; k++) begin
      exp_t e;
      model_step(tg);
      e.pc  = m_pc;
      e.tag = tg;
      exp_q.push_back(e);
    end
  endtask

  // monitor: one expected PC per clock once reset is released
  initial begin
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " pc"}, dbg_pc, e.pc);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin prog[i] = '0; m_mem[i] = '0; end
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
    prog[0]  = enc_i(6'h08, 0, 1, 5);          // addi r1 = 5
    prog[1]  = enc_i(6'h08, 0, 2, -3);         // addi r2 = -3
    prog[2]  = enc_r(1, 2, 3, 6'h20);          // add
    prog[3]  = enc_r(1, 2, 4, 6'h22);          // sub
    prog[4]  = enc_r(1, 2, 5, 6'h24);          // and
    prog[5]  = enc_r(1, 2, 6, 6'h25);          // or
    prog[6]  = enc_r(2, 1, 7, 6'h2A);          // slt -3 < 5
    prog[7]  = enc_r(1, 2, 8, 6'h2A);          // slt 5 < -3
    prog[8]  = enc_i(6'h08, 1, 0, 7);          // addi into r0
    prog[9]  = enc_i(6'h2B, 0, 1, 8);          // sw r1 -> word 2
    prog[10] = enc_i(6'h2B, 0, 2, 12);         // sw r2 -> word 3
    prog[11] = enc_i(6'h08, 0, 11, 4);         // r11 = 4
    prog[12] = enc_i(6'h23, 0, 9, 8);          // lw r9 <- word 2
    prog[13] = enc_i(6'h23, 11, 10, 8);        // lw r10 <- word 3
    prog[14] = enc_i(6'h04, 1, 9, 2);          // beq taken
    prog[15] = enc_i(6'h08, 0, 12, 99);
    prog[16] = enc_i(6'h08, 0, 12, 98);
    prog[17] = enc_i(6'h04, 1, 2, 5);          // beq not taken
    prog[18] = enc_i(6'h08, 0, 13, 1);
    prog[19] = 32'h0800_0000;                  // unknown opcode
    prog[20] = enc_r(1, 1, 14, 6'h00);         // unknown funct
    prog[21] = enc_r(1, 1, 0, 6'h20);          // add into r0
    prog[22] = enc_i(6'h04, 0, 0, -1);         // branch to self
    #1;
    for (int i = 0; i < 64; i++) u_scalar_core.imem[i] = prog[i];

    // reset state, R1 and R10
    repeat (2) @(negedge clk);
    check("R1 pc", dbg_pc, 32'd0);
    for (int i = 0; i < 32; i++) begin
      dbg_reg_sel = 5'(i);
      @(negedge clk);
      check("R1 reg", dbg_reg_data, 32'd0);
    end

    drive_program(30);
    rst_n = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    check("R8 halt loop", dbg_pc, 32'd88);

    // final register file against the interpreter (R10 debug read)
    for (int i = 0; i < 32; i++) begin
      dbg_reg_sel = 5'(i);
      #1;
      check("R10 reg", dbg_reg_data, m_reg[i]);
    end

    dbg_reg_sel = 5'd3;  #1; check("R3 add", dbg_reg_data, 32'd2);
    dbg_reg_sel = 5'd4;  #1; check("R3 sub", dbg_reg_data, 32'd8);
    dbg_reg_sel = 5'd5;  #1; check("R3 and", dbg_reg_data, 32'd5);
    dbg_reg_sel = 5'd6;  #1; check("R3 or", dbg_reg_data, 32'hFFFF_FFFD);
    dbg_reg_sel = 5'd7;  #1; check("R4 slt true", dbg_reg_data, 32'd1);
    dbg_reg_sel = 5'd8;  #1; check("R4 slt false", dbg_reg_data, 32'd0);
    dbg_reg_sel = 5'd2;  #1; check("R5 neg imm", dbg_reg_data, 32'hFFFF_FFFD);
    dbg_reg_sel = 5'd9;  #1; check("R6 stored word", dbg_reg_data, 32'd5);
    dbg_reg_sel = 5'd10; #1; check("R7 load offset", dbg_reg_data, 32'hFFFF_FFFD);
    dbg_reg_sel = 5'd12; #1; check("R8 skipped", dbg_reg_data, 32'd0);
    dbg_reg_sel = 5'd13; #1; check("R8 fallthrough", dbg_reg_data, 32'd1);
    dbg_reg_sel = 5'd0;  #1; check("R9 r0", dbg_reg_data, 32'd0);
    dbg_reg_sel = 5'd14; #1; check("R11 no write", dbg_reg_data, 32'd0);
    check("R10 pc", dbg_pc, m_pc);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule